// File: doc/BRIEF.md
# Unit-Triangular Factor Inverter

This block inverts the two unit-diagonal triangular factors of a packed LU matrix. The strictly lower part of an N×N array holds a unit lower factor, the strictly upper part holds a unit upper factor, and the diagonal is not used. A host writes the array through an indexed port while the block is idle and pulses `start`. The block then overwrites the strictly lower part with the inverse of the lower factor and the strictly upper part with the inverse of the upper factor. The host reads the result back through the same port.

The inverse of a unit triangular matrix is again unit triangular, so only off-diagonal terms are produced. For each index k, one shared sequence of counters handles column k of the lower factor and row k of the upper factor. Two working vectors are seeded with the negated source terms. For each position i after k, in ascending order, every later position j is then corrected by one rounded signed fixed-point product and one subtraction. Both factors are corrected in the same cycle. The finished column and row are written back in place. This is safe because later passes only read columns and rows with a higher index.

Top module: `unit_tri_inverter`

## Requirements
- R1: After reset `busy` and `done` are 0, and every array location reads as 0.
- R2: While `busy` is 0, a cycle with `memWrEn` high stores `memWrData` at location `memAddr`, where location = row·N + column. `memRdData` shows the location at `memAddr` combinationally. Addresses at or above N·N read as 0 and are not written.
- R3: The result at (j,k) with j>k is defined as follows. Start with sat(−a(j,k)). Then, for i = k+1 … j−1 in ascending order, subtract rnd(a(j,i)·b(i,k)), with a saturation after each subtraction. Here rnd(p) = (p + 2^(FRAC−1)) shifted arithmetically right by FRAC, and sat clamps to the signed WIDTH-bit range.
- R4: The result at (k,j) with j>k is defined the same way. Start with sat(−a(k,j)). Then, for ascending i between k and j, subtract rnd(b(k,i)·a(i,j)).
- R5: Diagonal locations are never changed by a run.
- R6: For inputs with off-diagonal magnitude below 0.25, the product of each factor with its computed inverse is within 8 LSB of the identity matrix.
- R7: A `start` seen while idle makes `busy` high from the next cycle for exactly Σ over k=0…N−2 of (2 + m(m−1)/2) + 1 cycles, where m = N−1−k. `done` is high for exactly one cycle, the last busy cycle.
- R8: While `busy` is high, `start` and host writes are ignored. The results equal those computed from the array as it was when the run started.
- R9: Negating the most negative code saturates to the most positive code. For example, the source term −2^(WIDTH−1) at (N−1,N−2) gives 2^(WIDTH−1)−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an inversion run (taken only while idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse in the last busy cycle |
| memWrEn | input | 1 | Host write strobe |
| memAddr | input | $clog2(N*N) | Location index row·N + column |
| memWrData | input | WIDTH | Host write data, signed fixed point |
| memRdData | output | WIDTH | Location contents at memAddr |

## Verification
The bench builds the block with N=5, WIDTH=16 and FRAC=10. With five rows, the column and row counters take every shape: passes with several correction steps, a pass with a single step, and a final pass with none. This exposes off-by-one errors in the loop limits and in the busy-cycle count. Ten fractional bits make the rounding visible in the low bits, so the exact check shows any error in the rounding offset or the shift. Full-range random inputs drive the saturation paths.

// File: rtl/unit_tri_inv_pkg.sv
package unit_tri_inv_pkg;

  typedef struct packed {
    logic loadVec;
    logic step;
    logic writeBack;
  } invStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_STEP,
    ST_STORE,
    ST_FIN
  } invState_t;

endpackage

// File: rtl/unit_tri_inv_ctrl.sv
module unit_tri_inv_ctrl
  import unit_tri_inv_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 2) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output invStrobe_t    strobe,
  output logic [IW-1:0] kIdx,
  output logic [IW-1:0] iIdx,
  output logic [IW-1:0] jIdx,
  output logic          busy,
  output logic          done
);

  localparam logic [IW-1:0] LAST   = IW'(N - 1);
  localparam logic [IW-1:0] PENULT = IW'(N - 2);

  invState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kIdx  <= '0;
      iIdx  <= '0;
      jIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            kIdx  <= '0;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          iIdx <= IW'(kIdx + 1'b1);
          jIdx <= IW'(kIdx + 2'd2);
          if (kIdx == PENULT) state <= ST_STORE;
          else                state <= ST_STEP;
        end
        ST_STEP: begin
          if (jIdx == LAST) begin
            if (iIdx == PENULT) begin
              state <= ST_STORE;
            end else begin
              iIdx <= IW'(iIdx + 1'b1);
              jIdx <= IW'(iIdx + 2'd2);
            end
          end else begin
            jIdx <= IW'(jIdx + 1'b1);
          end
        end
        ST_STORE: begin
          if (kIdx == PENULT) begin
            state <= ST_FIN;
          end else begin
            kIdx  <= IW'(kIdx + 1'b1);
            state <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadVec   = (state == ST_LOAD);
    strobe.step      = (state == ST_STEP);
    strobe.writeBack = (state == ST_STORE);
    busy             = (state != ST_IDLE);
    done             = (state == ST_FIN);
  end

  // R3: every correction step works on an index pair past the pivot
  assert_index_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> ((iIdx > kIdx) && (jIdx > iIdx) && (jIdx <= LAST)));

  // R7: the run ends right after the done pulse
  assert_done_ends_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R8: a start during a run cannot cut it short or restart it
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/unit_tri_inv_datapath.sv
module unit_tri_inv_datapath
  import unit_tri_inv_pkg::*;
#(
  parameter int N     = 4,
  parameter int WIDTH = 16,
  parameter int FRAC  = 8,
  localparam int IW = (N > 2) ? $clog2(N) : 1,
  localparam int AW = $clog2(N * N),
  localparam int XW = 2 * WIDTH + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  invStrobe_t              strobe,
  input  logic [IW-1:0]           kIdx,
  input  logic [IW-1:0]           iIdx,
  input  logic [IW-1:0]           jIdx,
  input  logic                    busy,
  input  logic                    memWrEn,
  input  logic [AW-1:0]           memAddr,
  input  logic signed [WIDTH-1:0] memWrData,
  output logic signed [WIDTH-1:0] memRdData
);

  localparam logic signed [XW-1:0] MAXV = {{(WIDTH+2){1'b0}}, {(WIDTH-1){1'b1}}};
  localparam logic signed [XW-1:0] MINV = {{(WIDTH+2){1'b1}}, {(WIDTH-1){1'b0}}};
  localparam logic signed [XW-1:0] HALF = XW'(1 << (FRAC - 1));

  logic signed [WIDTH-1:0] mat [N*N];
  logic signed [WIDTH-1:0] sl  [N];
  logic signed [WIDTH-1:0] su  [N];

  function automatic logic signed [WIDTH-1:0] satW(input logic signed [XW-1:0] v);
    if (v > MAXV)      return MAXV[WIDTH-1:0];
    else if (v < MINV) return MINV[WIDTH-1:0];
    else               return v[WIDTH-1:0];
  endfunction

  function automatic logic signed [XW-1:0] mulRound(input logic signed [WIDTH-1:0] a,
                                                    input logic signed [WIDTH-1:0] b);
    logic signed [2*WIDTH-1:0] prod;
    logic signed [XW-1:0]      ext;
    prod = a * b;
    ext  = XW'(prod) + HALF;
    return ext >>> FRAC;
  endfunction

  function automatic int loc(input int r, input int c);
    return r * N + c;
  endfunction

  logic signed [WIDTH-1:0] lowCoef, upCoef, lowPiv, upPiv;
  logic signed [WIDTH-1:0] lowNext, upNext;

  always_comb begin
    lowCoef = mat[loc(int'(jIdx), int'(iIdx))];
    upCoef  = mat[loc(int'(iIdx), int'(jIdx))];
    lowPiv  = sl[iIdx];
    upPiv   = su[iIdx];
    lowNext = satW(XW'(sl[jIdx]) - mulRound(lowCoef, lowPiv));
    upNext  = satW(XW'(su[jIdx]) - mulRound(upPiv, upCoef));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < N * N; a++) mat[a] <= '0;
      for (int v = 0; v < N; v++) begin
        sl[v] <= '0;
        su[v] <= '0;
      end
    end else begin
      if (memWrEn && !busy && (int'(memAddr) < N * N)) begin
        mat[memAddr] <= memWrData;
      end
      if (strobe.loadVec) begin
        for (int v = 0; v < N; v++) begin
          if (v > int'(kIdx)) begin
            sl[v] <= satW(-XW'(mat[loc(v, int'(kIdx))]));
            su[v] <= satW(-XW'(mat[loc(int'(kIdx), v)]));
          end
        end
      end
      if (strobe.step) begin
        sl[jIdx] <= lowNext;
        su[jIdx] <= upNext;
      end
      if (strobe.writeBack) begin
        for (int v = 0; v < N; v++) begin
          if (v > int'(kIdx)) begin
            mat[loc(v, int'(kIdx))] <= sl[v];
            mat[loc(int'(kIdx), v)] <= su[v];
          end
        end
      end
    end
  end

  always_comb begin
    if (int'(memAddr) < N * N) memRdData = mat[memAddr];
    else                       memRdData = '0;
  end

  logic [N*WIDTH-1:0] diagBits;
  for (genvar g = 0; g < N; g++) begin : gDiag
    assign diagBits[g*WIDTH +: WIDTH] = mat[g*N + g];
  end

  // R5: nothing on the diagonal moves while a run is active
  assert_diag_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(diagBits));

endmodule

// File: rtl/unit_tri_inverter.sv
module unit_tri_inverter
  import unit_tri_inv_pkg::*;
#(
  parameter int N     = 4,
  parameter int WIDTH = 16,
  parameter int FRAC  = 8,
  localparam int IW = (N > 2) ? $clog2(N) : 1,
  localparam int AW = $clog2(N * N)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  input  logic                    memWrEn,
  input  logic [AW-1:0]           memAddr,
  input  logic signed [WIDTH-1:0] memWrData,
  output logic signed [WIDTH-1:0] memRdData
);

  invStrobe_t    strobe;
  logic [IW-1:0] kIdx, iIdx, jIdx;

  unit_tri_inv_ctrl #(.N(N)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .kIdx   (kIdx),
    .iIdx   (iIdx),
    .jIdx   (jIdx),
    .busy   (busy),
    .done   (done)
  );

  unit_tri_inv_datapath #(.N(N), .WIDTH(WIDTH), .FRAC(FRAC)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .kIdx      (kIdx),
    .iIdx      (iIdx),
    .jIdx      (jIdx),
    .busy      (busy),
    .memWrEn   (memWrEn),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memRdData (memRdData)
  );

endmodule

// File: tb/test_unit_tri_inverter.sv
module test_unit_tri_inverter;

  localparam int N     = 5;
  localparam int WIDTH = 16;
  localparam int FRAC  = 10;
  localparam int AW    = $clog2(N * N);
  localparam longint MAXV = (64'sd1 <<< (WIDTH - 1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (WIDTH - 1));
  localparam longint ONE  = 64'sd1 <<< FRAC;

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic busy, done;
  logic memWrEn = 0;
  logic [AW-1:0] memAddr = '0;
  logic signed [WIDTH-1:0] memWrData = '0;
  logic signed [WIDTH-1:0] memRdData;

  int checks = 0;
  int failures = 0;
  longint cycleCount = 0;

  longint src [N][N];
  longint expv [N][N];
  longint got [N][N];

  unit_tri_inverter #(.N(N), .WIDTH(WIDTH), .FRAC(FRAC)) i_unit_tri_inverter (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000) begin
      failures++;
      $display("FAIL watchdog R7 act=%0d expected<=150000", cycleCount);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic longint rnd(input longint p);
    return (p + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
  endfunction

  // R3, R4 reference from the requirement formulas
  task automatic computeExpected();
    longint lv [N];
    longint uv [N];
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) expv[r][c] = src[r][c];
    for (int k = 0; k < N - 1; k++) begin
      for (int v = k + 1; v < N; v++) begin
        lv[v] = sat(-src[v][k]);
        uv[v] = sat(-src[k][v]);
      end
      for (int i = k + 1; i < N - 1; i++)
        for (int j = i + 1; j < N; j++) begin
          lv[j] = sat(lv[j] - rnd(src[j][i] * lv[i]));
          uv[j] = sat(uv[j] - rnd(uv[i] * src[i][j]));
        end
      for (int v = k + 1; v < N; v++) begin
        expv[v][k] = lv[v];
        expv[k][v] = uv[v];
      end
    end
  endtask

  task automatic writeMat();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        @(negedge clk);
        memWrEn = 1;
        memAddr = AW'(r * N + c);
        memWrData = WIDTH'(src[r][c]);
      end
    @(negedge clk);
    memWrEn = 0;
  endtask

  task automatic readAll();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        @(negedge clk);
        memAddr = AW'(r * N + c);
        #1;
        got[r][c] = longint'(memRdData);
      end
  endtask

  function automatic int expBusy();
    int t = 1;
    for (int k = 0; k < N - 1; k++) begin
      int m = N - 1 - k;
      t += 2 + m * (m - 1) / 2;
    end
    return t;
  endfunction

  task automatic runInv(input bit interfere, output int busyCyc, output int doneCyc);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    busyCyc = 0;
    doneCyc = 0;
    while (busy) begin
      busyCyc++;
      if (done) doneCyc++;
      if (interfere && busyCyc == 3) begin
        start = 1;
        memWrEn = 1;
        memAddr = AW'((N - 1) * N);
        memWrData = 16'sh1234;
      end else begin
        start = 0;
        memWrEn = 0;
      end
      @(negedge clk);
    end
    start = 0;
    memWrEn = 0;
  endtask

  task automatic checkExact(input string tag);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        if (r > c)      chk(got[r][c] == expv[r][c], {"R3 lower ", tag}, got[r][c], expv[r][c]);
        else if (r < c) chk(got[r][c] == expv[r][c], {"R4 upper ", tag}, got[r][c], expv[r][c]);
        else            chk(got[r][c] == src[r][c], {"R5 diagonal ", tag}, got[r][c], src[r][c]);
      end
  endtask

  task automatic checkIdentity();
    for (int k = 0; k < N; k++)
      for (int j = k + 1; j < N; j++) begin
        longint accL = 0;
        longint accU = 0;
        for (int t = k; t <= j; t++) begin
          longint aL = (t == j) ? ONE : src[j][t];
          longint bL = (t == k) ? ONE : got[t][k];
          longint bU = (t == k) ? ONE : got[k][t];
          longint aU = (t == j) ? ONE : src[t][j];
          accL += aL * bL;
          accU += bU * aU;
        end
        chk((accL <= 8 * ONE) && (accL >= -8 * ONE), "R6 lower identity", accL >>> FRAC, 0);
        chk((accU <= 8 * ONE) && (accU >= -8 * ONE), "R6 upper identity", accU >>> FRAC, 0);
      end
  endtask

  task automatic fullRun(input bit interfere, input bit identity, input string tag);
    int bc, dc;
    writeMat();
    computeExpected();
    runInv(interfere, bc, dc);
    chk(bc == expBusy(), "R7 busy cycles", bc, expBusy());
    chk(dc == 1, "R7 done pulses", dc, 1);
    readAll();
    checkExact(tag);
    if (identity) checkIdentity();
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED1234);

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy after reset", longint'(busy), 0);
    chk(done == 0, "R1 done after reset", longint'(done), 0);
    readAll();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) chk(got[r][c] == 0, "R1 array cleared", got[r][c], 0);

    // R2 write/readback and out-of-range address
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) src[r][c] = longint'($signed(16'(r * 97 - c * 31)));
    writeMat();
    readAll();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) chk(got[r][c] == src[r][c], "R2 readback", got[r][c], src[r][c]);
    @(negedge clk);
    memWrEn = 1;
    memAddr = AW'(N * N);
    memWrData = 16'sh7777;
    @(negedge clk);
    memWrEn = 0;
    #1;
    chk(memRdData == 0, "R2 out-of-range read", longint'(memRdData), 0);

    // Directed: all-zero off-diagonal gives zero inverse
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) src[r][c] = (r == c) ? ONE : 0;
    fullRun(0, 1, "zero");

    // Random small entries, exact and identity checks
    for (int t = 0; t < 12; t++) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          src[r][c] = (r == c) ? longint'($signed(16'($urandom)))
                               : longint'($urandom % 512) - 256;
      fullRun(0, 1, "random");
    end

    // R9 saturation: most negative code negated
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) src[r][c] = 0;
    src[N-1][N-2] = MINV;
    src[N-2][N-1] = MINV;
    fullRun(0, 0, "sat");
    chk(got[N-1][N-2] == MAXV, "R9 lower negation saturates", got[N-1][N-2], MAXV);
    chk(got[N-2][N-1] == MAXV, "R9 upper negation saturates", got[N-2][N-1], MAXV);

    // Full-range random entries drive saturation in the correction steps
    for (int t = 0; t < 4; t++) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) src[r][c] = longint'($signed(16'($urandom)));
      fullRun(0, 0, "fullrange");
    end

    // R8 write and start during a run are ignored
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        src[r][c] = (r == c) ? 100 : longint'($urandom % 512) - 256;
    fullRun(1, 0, "R8 interfered");
    chk(busy == 0, "R8 idle after interfered run", longint'(busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule